// File: doc/BRIEF.md
# Status Register and Write Guard

This block keeps the eight-bit status byte of a serial non-volatile memory and decides whether a write is allowed. The write may target the array or the status byte itself. A command engine drives it with one-cycle strobes, each marking a decoded instruction: write enable, write disable, status write (with its data byte) and array write (with its target address). A write-cycle-done pulse tells the block that the programming cycle has ended. The block answers with a one-cycle `write_ok` pulse when it accepts a write. The status byte is always visible for read-back.

The two zone bits mark part of the array as read-only. The choices are nothing, the top quarter, the top half, or the whole array. A lock bit and the active-low write-protect pin together freeze the zone bits and the lock bit. These three bits live in flops that the synchronous reset leaves alone, which models non-volatile storage. The bits taken from a status write are committed only when that write cycle completes.

Top module: `sreg_guard`

## Requirements
- R1: After `rst`, the enable bit, the busy bit and `write_ok` are 0.
- R2: The status byte reads as follows. Bit 7 is the lock bit and bits 6..4 are always 0. Bits 3:2 hold the zone code, with bit 3 as the upper bit. Bit 1 is the write-enable bit and bit 0 is the busy bit.
- R3: A write-enable strobe sets bit 1. A write-disable strobe clears it.
- R4: An array or status write strobe given while bit 1 is 0 is rejected. It produces no `write_ok`, and bit 0 stays 0.
- R5: With a 13-bit address, zone code 0 protects nothing. Code 1 protects 0x1800..0x1FFF, code 2 protects 0x1000..0x1FFF, and code 3 protects every address. An array write to a protected address is rejected.
- R6: An accepted write gives `write_ok` high for exactly one cycle, in the cycle after the strobe. Bit 0 is also set in that cycle. Bit 0 stays set until `wr_done` arrives, and then bits 0 and 1 both clear.
- R7: A rejected array write clears bit 1 and leaves bit 0 at 0.
- R8: An accepted status write takes only data bits 7, 3 and 2. The new values show in the status byte only after `wr_done`.
- R9: While the lock bit is 1 and `wprot_n` is 0, a status write is rejected: bit 1 clears and bits 7, 3 and 2 keep their values. With `wprot_n` at 1, the same write is accepted.
- R10: While bit 0 is 1, write-enable, write-disable and write strobes have no effect. A `wr_done` pulse given while bit 0 is 0 also has no effect.
- R11: `rst` does not change the lock bit or the zone bits. `nv_bits` reports them as {lock, zone[1], zone[0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| wprot_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Write-enable instruction strobe |
| cmd_wrdi | input | 1 | Write-disable instruction strobe |
| cmd_wrsr | input | 1 | Status-write instruction strobe |
| cmd_write | input | 1 | Array-write instruction strobe |
| wr_data | input | 8 | Data byte carried with a status write |
| addr | input | ADDR_W | Target address carried with an array write |
| wr_done | input | 1 | Pulse at the end of the internal write cycle |
| status_byte | output | 8 | Status byte for read-back |
| write_ok | output | 1 | One-cycle pulse when a write is accepted |
| nv_bits | output | 3 | Non-volatile bits {lock, zone[1], zone[0]} |

## Verification
A vector walk sets each zone code in turn and probes addresses just below and just above every zone boundary, plus address zero and the top address. This separates a wrong boundary bit from a wrong code-to-zone mapping. Directed sequences probe these cases:
- writes without a prior enable;
- strobes that arrive while busy;
- stray done pulses;
- status writes with every data bit set, which shows that the unused bits are dropped;
- the lock bit with the pin both low and high, which separates the hardware freeze from plain enable gating;
- a reset with non-zero protect bits.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;
  typedef enum logic [1:0] {
    ZONE_NONE    = 2'd0,
    ZONE_QUARTER = 2'd1,
    ZONE_HALF    = 2'd2,
    ZONE_ALL     = 2'd3
  } zone_e;

  typedef enum logic {
    JOB_ARRAY  = 1'b0,
    JOB_STATUS = 1'b1
  } job_e;

  // positions in the status byte that a status write may change
  localparam int LOCK_POS   = 7;
  localparam int ZONE_HI    = 3;
  localparam int ZONE_LO    = 2;
  localparam int NV_W       = 3;
endpackage

// File: rtl/sreg_zone_check.sv
module sreg_zone_check
  import sreg_guard_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  zone_e              zone,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (zone)
      ZONE_NONE:    hit = 1'b0;
      ZONE_QUARTER: hit = addr[TOP] & addr[TOP-1];
      ZONE_HALF:    hit = addr[TOP];
      default:      hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/sreg_nv_bits.sv
module sreg_nv_bits
  import sreg_guard_pkg::*;
#(
  parameter logic [NV_W-1:0] NV_INIT = '0
) (
  input  logic             clk,
  input  logic             commit,
  input  logic [NV_W-1:0]  din,
  output logic [NV_W-1:0]  nv
);
  // no reset on purpose: these flops model cells that keep their value
  logic [NV_W-1:0] nv_q = NV_INIT;

  always_ff @(posedge clk) begin
    if (commit) nv_q <= din;
  end

  assign nv = nv_q;
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_guard_pkg::*;
#(
  parameter int              ADDR_W  = 13,
  parameter logic [NV_W-1:0] NV_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wprot_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_write,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_done,
  output logic [7:0]        status_byte,
  output logic              write_ok,
  output logic [NV_W-1:0]   nv_bits
);
  logic            wel_q, wip_q, ok_q;
  job_e            job_q;
  logic [NV_W-1:0] pend_q;
  logic [NV_W-1:0] nv;
  logic            zone_hit, hw_lock;
  logic            arr_req, arr_go, st_req, st_go, finish, commit;

  sreg_zone_check #(.ADDR_W(ADDR_W)) u_zone (
    .zone (zone_e'(nv[1:0])),
    .addr (addr),
    .hit  (zone_hit)
  );

  sreg_nv_bits #(.NV_INIT(NV_INIT)) u_nv (
    .clk    (clk),
    .commit (commit),
    .din    (pend_q),
    .nv     (nv)
  );

  always_comb begin
    hw_lock = nv[2] & ~wprot_n;
    arr_req = cmd_write & ~wip_q;
    arr_go  = arr_req & wel_q & ~zone_hit;
    st_req  = cmd_wrsr & ~wip_q;
    st_go   = st_req & wel_q & ~hw_lock;
    finish  = wr_done & wip_q;
    commit  = finish & (job_q == JOB_STATUS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q  <= 1'b0;
      wip_q  <= 1'b0;
      ok_q   <= 1'b0;
      job_q  <= JOB_ARRAY;
      pend_q <= '0;
    end else begin
      ok_q <= arr_go | st_go;
      if (finish) begin
        wip_q <= 1'b0;
        wel_q <= 1'b0;
      end else if (!wip_q) begin
        if (arr_go || st_go) begin
          wip_q <= 1'b1;
          job_q <= st_go ? JOB_STATUS : JOB_ARRAY;
          if (st_go) pend_q <= {wr_data[LOCK_POS], wr_data[ZONE_HI], wr_data[ZONE_LO]};
        end else if (arr_req || st_req) begin
          wel_q <= 1'b0;
        end else if (cmd_wren) begin
          wel_q <= 1'b1;
        end else if (cmd_wrdi) begin
          wel_q <= 1'b0;
        end
      end
    end
  end

  assign status_byte = {nv[2], 3'b000, nv[1:0], wel_q, wip_q};
  assign write_ok    = ok_q;
  assign nv_bits     = nv;

  // R6: acceptance pulse lasts one cycle
  a_r6_ok_single: assert property (@(posedge clk) disable iff (rst)
    ok_q |=> !ok_q);
  // R10: nothing is accepted while a cycle runs
  a_r10_busy_quiet: assert property (@(posedge clk) disable iff (rst)
    wip_q |=> !ok_q);
  // R4: no acceptance without the enable bit
  a_r4_need_enable: assert property (@(posedge clk) disable iff (rst)
    !wel_q |=> !ok_q);
  // R6: done ends the cycle and drops the enable bit
  a_r6_done_clears: assert property (@(posedge clk) disable iff (rst)
    (wip_q && wr_done) |=> (!wip_q && !wel_q));
  // R7: write into a protected zone is refused and disarms
  a_r7_reject_clears: assert property (@(posedge clk) disable iff (rst)
    (cmd_write && !wip_q && zone_hit) |=> (!wel_q && !wip_q && !ok_q));
  // R9: frozen bits do not move under hardware protection
  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    (nv[2] && !wprot_n && !wip_q) |=> $stable(nv));
endmodule

// File: tb/tb_sreg_guard.sv
module tb_sreg_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wprot_n = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0, wr_done = 0;
  logic [7:0] wr_data = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] status_byte;
  logic write_ok;
  logic [2:0] nv_bits;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sreg_guard #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .wprot_n(wprot_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .cmd_write(cmd_write), .wr_data(wr_data), .addr(addr),
    .wr_done(wr_done), .status_byte(status_byte), .write_ok(write_ok),
    .nv_bits(nv_bits)
  );

  // {zone code, address, expected acceptance}
  localparam logic [15:0] VEC [0:11] = '{
    {2'd0, 13'h1FFF, 1'b1}, {2'd0, 13'h0000, 1'b1},
    {2'd1, 13'h17FF, 1'b1}, {2'd1, 13'h1800, 1'b0},
    {2'd1, 13'h1FFF, 1'b0}, {2'd1, 13'h0000, 1'b1},
    {2'd2, 13'h0FFF, 1'b1}, {2'd2, 13'h1000, 1'b0},
    {2'd2, 13'h17FF, 1'b0}, {2'd2, 13'h0000, 1'b1},
    {2'd3, 13'h0000, 1'b0}, {2'd3, 13'h0FFF, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // kind: 0 wren, 1 wrdi, 2 wrsr, 3 write, 4 done
  task automatic strobe(input int kind, input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    wr_data = d; addr = a;
    cmd_wren  = (kind == 0);
    cmd_wrdi  = (kind == 1);
    cmd_wrsr  = (kind == 2);
    cmd_write = (kind == 3);
    wr_done   = (kind == 4);
    @(negedge clk);
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_write = 0; wr_done = 0;
  endtask

  task automatic set_status(input logic [7:0] d);
    strobe(0, 8'h00, '0);
    strobe(2, d, '0);
    strobe(4, 8'h00, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 status after reset", status_byte, 8'h00);
    chk("R1 write_ok after reset", write_ok, 0);

    // R3 enable then disable
    strobe(0, 8'h00, '0);
    chk("R3 wren sets bit1", status_byte[1], 1);
    strobe(1, 8'h00, '0);
    chk("R3 wrdi clears bit1", status_byte[1], 0);

    // R4 write without enable
    strobe(3, 8'h00, 13'h0000);
    chk("R4 no ok without enable", write_ok, 0);
    chk("R4 busy stays low", status_byte[0], 0);
    strobe(2, 8'h8C, '0);
    chk("R4 status write refused", {write_ok, status_byte}, {1'b0, 8'h00});

    // R5 zone walk, R6 / R7 outcomes
    for (int i = 0; i < 12; i++) begin
      set_status({4'b0000, VEC[i][15:14], 2'b00});
      strobe(0, 8'h00, '0);
      strobe(3, 8'h00, VEC[i][13:1]);
      chk("R5 zone acceptance", write_ok, VEC[i][0]);
      chk("R6 busy follows acceptance", status_byte[0], VEC[i][0]);
      if (VEC[i][0]) begin
        @(negedge clk);
        chk("R6 ok lasts one cycle", write_ok, 0);
        strobe(4, 8'h00, '0);
        chk("R6 done clears bits 1:0", status_byte[1:0], 0);
      end else begin
        chk("R7 reject clears enable", status_byte[1:0], 0);
      end
    end

    // R8 / R2 status write with all data bits set
    set_status(8'h00);
    strobe(0, 8'h00, '0);
    strobe(2, 8'hFF, '0);
    chk("R8 accepted status write", write_ok, 1);
    chk("R8 bits held until done", status_byte, 8'h03);
    strobe(4, 8'h00, '0);
    chk("R2 R8 layout after commit", status_byte, 8'h8C);

    // R10 strobes ignored while busy, stray done ignored
    set_status(8'h00);
    strobe(0, 8'h00, '0);
    strobe(3, 8'h00, 13'h0010);
    strobe(1, 8'h00, '0);
    chk("R10 wrdi ignored while busy", status_byte[1:0], 2'b11);
    strobe(3, 8'h00, 13'h0020);
    chk("R10 write ignored while busy", write_ok, 0);
    strobe(4, 8'h00, '0);
    strobe(0, 8'h00, '0);
    strobe(4, 8'h00, '0);
    chk("R10 stray done ignored", status_byte, 8'h02);
    strobe(1, 8'h00, '0);

    // R9 hardware freeze
    set_status(8'h84);
    chk("R9 lock set with pin high", status_byte, 8'h84);
    wprot_n = 0;
    strobe(0, 8'h00, '0);
    strobe(2, 8'h00, '0);
    chk("R9 frozen write refused", write_ok, 0);
    chk("R9 bits kept, enable cleared", status_byte, 8'h84);
    wprot_n = 1;
    strobe(0, 8'h00, '0);
    strobe(2, 8'h88, '0);
    chk("R9 pin high accepts", write_ok, 1);
    strobe(4, 8'h00, '0);
    chk("R9 new value committed", status_byte, 8'h88);

    // R11 reset keeps protect bits
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R11 status after reset", status_byte, 8'h88);
    chk("R11 nv_bits order", nv_bits, 3'b110);

    finish_run();
  end
endmodule